// File: doc/BRIEF.md
# Byte-Lane Load/Store Data Aligner

This block sits between a processor datapath and a 32-bit, byte-addressed memory bus. On the store side, it takes a register value, an access size and the low address bits. It produces the bus write word and one write enable per byte lane. On the load side, it takes the word returned by the bus and extracts the addressed byte, halfword or word. It then returns that value zero-extended or sign-extended to the full register width.

A single configuration input selects how byte addresses are numbered within a word. With the input low, the least significant byte of a word lives at the lowest address. With it high, the most significant byte does. Both directions follow the same lane mapping, so a value written and read back at the same address and size is recovered in either numbering.

A store and a load can be presented in the same cycle through their separate request inputs. Their results appear on registered outputs one clock later. Unaligned word or halfword accesses are not detected; the address bits below the access size are simply dropped.

Top module: `lsa_aligner`

## Requirements
- R1: A load with `ld_size`=0 (byte) and `ld_signed`=0 returns the addressed byte in `ld_data[7:0]`, with bits 31:8 cleared.
- R2: A load with `ld_size`=1 (halfword) and `ld_signed`=0 returns the addressed halfword in `ld_data[15:0]`, with bits 31:16 cleared.
- R3: A byte load with `ld_signed`=1 fills `ld_data[31:8]` with bit 7 of the selected byte.
- R4: A halfword load with `ld_signed`=1 fills `ld_data[31:16]` with bit 15 of the selected halfword.
- R5: A store with `st_size`=0 drives `st_value[7:0]` onto all four lanes of `wr_data` and raises exactly one bit of `wr_be`.
- R6: A store with `st_size`=1 drives `st_value[15:0]` onto both halves of `wr_data` and raises exactly two adjacent bits of `wr_be`: either 0011 or 1100.
- R7: A store with `st_size`=2 or 3 (word) passes `st_value` through unchanged and raises all four bits of `wr_be`.
- R8: With `big_endian`=0, byte offset k uses lane k, meaning bits 8k+7:8k and `wr_be[k]`. A halfword with address bit 1 clear uses lanes 1:0, and one with it set uses lanes 3:2. Storing word 0x11223344 at address 0 puts 0x44 at address 0, and a byte load from address 0 then returns 0x44.
- R9: With `big_endian`=1, byte offset k uses lane 3-k. A halfword with address bit 1 clear uses lanes 3:2, and one with it set uses lanes 1:0. Storing word 0x11223344 at address 0 puts 0x11 at address 0, and a byte load from address 0 then returns 0x11.
- R10: Address bit 0 has no effect on halfword accesses. Both address bits have no effect on word accesses. A word load returns `rd_word` unchanged.
- R11: Outputs are registered and update on the clock edge after the request. In the cycle after `st_req` is low, `wr_be` is 0000. `ld_data` holds its value while `ld_req` is low.
- R12: During reset and right after it, `wr_data`, `wr_be` and `ld_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| big_endian | input | 1 | 0: lowest address holds the least significant byte; 1: it holds the most significant byte |
| st_req | input | 1 | Store request this cycle |
| st_size | input | 2 | Store size: 0 byte, 1 halfword, 2 or 3 word |
| st_addr | input | 2 | Low address bits of the store |
| st_value | input | 32 | Register value to store |
| wr_data | output | 32 | Bus write word, lanes replicated |
| wr_be | output | 4 | Per-lane write enables, bit k for bits 8k+7:8k |
| ld_req | input | 1 | Load request this cycle |
| ld_size | input | 2 | Load size: 0 byte, 1 halfword, 2 or 3 word |
| ld_addr | input | 2 | Low address bits of the load |
| ld_signed | input | 1 | 1: sign-extend, 0: zero-extend |
| rd_word | input | 32 | Word read from the bus for this load |
| ld_data | output | 32 | Extended load result |

## Verification
A store and a load can be issued in the same cycle, and both use the one endianness input. The main sweep does exactly that. In every step it pairs a store and a load that have independent sizes, offsets and data, under both numberings. The two results are then judged separately against values worked out arithmetically from the requirements. A small byte-addressed memory model in the bench carries the R8 and R9 example from a store to a later load. Idle cycles between the sweeps confirm that `wr_be` clears and that `ld_data` holds.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  function automatic logic sz_is_byte(input logic [1:0] sz);
    return sz == SZ_BYTE;
  endfunction

  function automatic logic sz_is_half(input logic [1:0] sz);
    return sz == SZ_HALF;
  endfunction
endpackage

// File: rtl/lsa_lane_sel.sv
// Maps a byte offset to a bus lane and a halfword offset to a lane pair.
module lsa_lane_sel #(
  parameter int LANES = 4,
  localparam int OFS_W = $clog2(LANES),
  localparam int HIX_W = (OFS_W > 1) ? OFS_W - 1 : 1
) (
  input  logic             big,
  input  logic [OFS_W-1:0] ofs,
  output logic [OFS_W-1:0] byte_lane,
  output logic [HIX_W-1:0] half_idx
);
  always_comb begin
    if (big) begin
      byte_lane = OFS_W'(LANES - 1) - ofs;
      half_idx  = HIX_W'(LANES / 2 - 1) - ofs[OFS_W-1:1];
    end else begin
      byte_lane = ofs;
      half_idx  = ofs[OFS_W-1:1];
    end
  end
endmodule

// File: rtl/lsa_store_path.sv
// Replicates the stored value across lanes and builds lane enables.
module lsa_store_path
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int OFS_W = $clog2(LANES),
  localparam int HIX_W = (OFS_W > 1) ? OFS_W - 1 : 1
) (
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] value,
  input  logic [OFS_W-1:0]  byte_lane,
  input  logic [HIX_W-1:0]  half_idx,
  output logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  be
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      if (sz_is_byte(size)) begin
        wdata[i*LANE_W +: LANE_W] = value[LANE_W-1:0];
        be[i] = (byte_lane == OFS_W'(i));
      end else if (sz_is_half(size)) begin
        wdata[i*LANE_W +: LANE_W] = value[(i%2)*LANE_W +: LANE_W];
        be[i] = (half_idx == HIX_W'(i / 2));
      end else begin
        wdata[i*LANE_W +: LANE_W] = value[i*LANE_W +: LANE_W];
        be[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lsa_load_path.sv
// Extracts the addressed byte or halfword and extends it.
module lsa_load_path
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int OFS_W = $clog2(LANES),
  localparam int HIX_W = (OFS_W > 1) ? OFS_W - 1 : 1,
  localparam int HALF_W = 2 * LANE_W
) (
  input  logic [1:0]        size,
  input  logic              sgn,
  input  logic [DATA_W-1:0] rd_word,
  input  logic [OFS_W-1:0]  byte_lane,
  input  logic [HIX_W-1:0]  half_idx,
  output logic [DATA_W-1:0] result
);
  logic [LANE_W-1:0] sel_byte;
  logic [HALF_W-1:0] sel_half;
  logic              fill;

  always_comb begin
    sel_byte = rd_word[int'(byte_lane)*LANE_W +: LANE_W];
    sel_half = rd_word[int'(half_idx)*HALF_W +: HALF_W];
    if (sz_is_byte(size)) begin
      fill   = sgn & sel_byte[LANE_W-1];
      result = {{(DATA_W-LANE_W){fill}}, sel_byte};
    end else if (sz_is_half(size)) begin
      fill   = sgn & sel_half[HALF_W-1];
      result = {{(DATA_W-HALF_W){fill}}, sel_half};
    end else begin
      fill   = 1'b0;
      result = rd_word;
    end
  end
endmodule

// File: rtl/lsa_aligner.sv
module lsa_aligner
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int OFS_W = $clog2(LANES),
  localparam int HIX_W = (OFS_W > 1) ? OFS_W - 1 : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian,
  input  logic              st_req,
  input  logic [1:0]        st_size,
  input  logic [OFS_W-1:0]  st_addr,
  input  logic [DATA_W-1:0] st_value,
  output logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  wr_be,
  input  logic              ld_req,
  input  logic [1:0]        ld_size,
  input  logic [OFS_W-1:0]  ld_addr,
  input  logic              ld_signed,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] ld_data
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Store side.
  logic [OFS_W-1:0]  st_lane;
  logic [HIX_W-1:0]  st_hidx;
  logic [DATA_W-1:0] st_wdata;
  logic [LANES-1:0]  st_be;

  lsa_lane_sel #(.LANES(LANES)) u_st_sel (
    .big(big_endian), .ofs(st_addr), .byte_lane(st_lane), .half_idx(st_hidx)
  );

  lsa_store_path #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_st (
    .size(st_size), .value(st_value), .byte_lane(st_lane),
    .half_idx(st_hidx), .wdata(st_wdata), .be(st_be)
  );

  // Load side.
  logic [OFS_W-1:0]  ld_lane;
  logic [HIX_W-1:0]  ld_hidx;
  logic [DATA_W-1:0] ld_result;

  lsa_lane_sel #(.LANES(LANES)) u_ld_sel (
    .big(big_endian), .ofs(ld_addr), .byte_lane(ld_lane), .half_idx(ld_hidx)
  );

  lsa_load_path #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_ld (
    .size(ld_size), .sgn(ld_signed), .rd_word(rd_word),
    .byte_lane(ld_lane), .half_idx(ld_hidx), .result(ld_result)
  );

  // Output registers: next-state logic.
  logic [DATA_W-1:0] wr_data_d, ld_data_d;
  logic [LANES-1:0]  wr_be_d;

  always_comb begin
    wr_data_d = wr_data;
    wr_be_d   = '0;
    ld_data_d = ld_data;
    if (st_req) begin
      wr_data_d = st_wdata;
      wr_be_d   = st_be;
    end
    if (ld_req) ld_data_d = ld_result;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      wr_data <= '0;
      wr_be   <= '0;
      ld_data <= '0;
    end else begin
      wr_data <= wr_data_d;
      wr_be   <= wr_be_d;
      ld_data <= ld_data_d;
    end
  end

  // Checks on the registered outputs.
  a_r1_ubyte_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    ld_req && sz_is_byte(ld_size) && !ld_signed |=> ld_data[DATA_W-1:LANE_W] == '0);
  a_r3_sbyte_fill: assert property (@(posedge clk) disable iff (!rst_int_n)
    ld_req && sz_is_byte(ld_size) && ld_signed
    |=> ld_data[DATA_W-1:LANE_W] == {(DATA_W-LANE_W){ld_data[LANE_W-1]}});
  a_r4_shalf_fill: assert property (@(posedge clk) disable iff (!rst_int_n)
    ld_req && sz_is_half(ld_size) && ld_signed
    |=> ld_data[DATA_W-1:2*LANE_W] == {(DATA_W-2*LANE_W){ld_data[2*LANE_W-1]}});
  a_r5_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_int_n)
    st_req && sz_is_byte(st_size)
    |=> $countones(wr_be) == 1 && wr_data[LANE_W-1:0] == wr_data[DATA_W-1 -: LANE_W]);
  a_r6_half_two_lanes: assert property (@(posedge clk) disable iff (!rst_int_n)
    st_req && sz_is_half(st_size) |=> $countones(wr_be) == 2);
  a_r7_word_all_lanes: assert property (@(posedge clk) disable iff (!rst_int_n)
    st_req && !sz_is_byte(st_size) && !sz_is_half(st_size) |=> &wr_be);
  a_r9_be_top_lane: assert property (@(posedge clk) disable iff (!rst_int_n)
    st_req && sz_is_byte(st_size) && big_endian && st_addr == '0 |=> wr_be[LANES-1]);
  a_r11_idle_no_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    !st_req |=> wr_be == '0);
  a_r11_load_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ld_req |=> $stable(ld_data));
endmodule

// File: tb/tb_lsa_aligner.sv
`timescale 1ns/1ps
module tb_lsa_aligner;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        big_endian;
  logic        st_req;
  logic [1:0]  st_size;
  logic [1:0]  st_addr;
  logic [31:0] st_value;
  logic [31:0] wr_data;
  logic [3:0]  wr_be;
  logic        ld_req;
  logic [1:0]  ld_size;
  logic [1:0]  ld_addr;
  logic        ld_signed;
  logic [31:0] rd_word;
  logic [31:0] ld_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] mem [0:3];

  always #5 clk = ~clk;

  lsa_aligner dut (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
    .st_req(st_req), .st_size(st_size), .st_addr(st_addr), .st_value(st_value),
    .wr_data(wr_data), .wr_be(wr_be),
    .ld_req(ld_req), .ld_size(ld_size), .ld_addr(ld_addr), .ld_signed(ld_signed),
    .rd_word(rd_word), .ld_data(ld_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] exp_load(input logic be, input logic [1:0] sz,
      input logic [1:0] a, input logic sg, input logic [31:0] rd);
    int lane, hidx;
    logic [31:0] b, h;
    lane = be ? 3 - int'(a) : int'(a);
    hidx = be ? 1 - int'(a[1]) : int'(a[1]);
    b = (rd >> (8 * lane)) & 32'hFF;
    h = (rd >> (16 * hidx)) & 32'hFFFF;
    if (sz == 2'd0) return (sg && b[7]) ? (b | 32'hFFFF_FF00) : b;
    if (sz == 2'd1) return (sg && h[15]) ? (h | 32'hFFFF_0000) : h;
    return rd;
  endfunction

  function automatic logic [35:0] exp_store(input logic be, input logic [1:0] sz,
      input logic [1:0] a, input logic [31:0] v);
    int lane, hidx;
    lane = be ? 3 - int'(a) : int'(a);
    hidx = be ? 1 - int'(a[1]) : int'(a[1]);
    if (sz == 2'd0) return {4'(1 << lane), {4{v[7:0]}}};
    if (sz == 2'd1) return {4'(3 << (2 * hidx)), {2{v[15:0]}}};
    return {4'hF, v};
  endfunction

  function automatic string ld_tag(input logic [1:0] sz, input logic [1:0] a, input logic sg);
    if (sz == 2'd0) return sg ? "R3" : "R1";
    if (sz == 2'd1) return a[0] ? "R10" : (sg ? "R4" : "R2");
    return "R10";
  endfunction

  function automatic string st_tag(input logic [1:0] sz, input logic [1:0] a);
    if (sz == 2'd0) return "R5";
    if (sz == 2'd1) return a[0] ? "R10" : "R6";
    return (a != 2'd0) ? "R10" : "R7";
  endfunction

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [35:0] es;
    logic [31:0] held;
    rst_n = 1'b0; big_endian = 1'b0;
    st_req = 1'b0; st_size = 2'd0; st_addr = 2'd0; st_value = '0;
    ld_req = 1'b0; ld_size = 2'd0; ld_addr = 2'd0; ld_signed = 1'b0; rd_word = '0;
    repeat (3) step();
    // R12: outputs zero while in reset
    chk("R12 wr_data", wr_data, 32'h0);
    chk("R12 wr_be", {28'h0, wr_be}, 32'h0);
    chk("R12 ld_data", ld_data, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) step();
    chk("R12 ld_data after release", ld_data, 32'h0);

    // R8 / R9: word store at 0, then byte load at 0 through a memory model
    for (int e = 0; e < 2; e++) begin
      @(negedge clk);
      big_endian = e[0];
      st_req = 1'b1; st_size = 2'd2; st_addr = 2'd0; st_value = 32'h1122_3344;
      step();
      for (int k = 0; k < 4; k++)
        if (wr_be[k]) mem[e ? 3 - k : k] = wr_data[8*k +: 8];
      chk(e ? "R9 byte at addr0" : "R8 byte at addr0", {24'h0, mem[0]},
          e ? 32'h11 : 32'h44);
      @(negedge clk);
      st_req = 1'b0;
      ld_req = 1'b1; ld_size = 2'd0; ld_addr = 2'd0; ld_signed = 1'b0;
      for (int k = 0; k < 4; k++) rd_word[8*k +: 8] = mem[e ? 3 - k : k];
      step();
      chk(e ? "R9 load addr0" : "R8 load addr0", ld_data, e ? 32'h11 : 32'h44);
      @(negedge clk); ld_req = 1'b0;
    end

    // Sweep: store and load issued in the same cycle
    for (int e = 0; e < 2; e++)
      for (int sz = 0; sz < 4; sz++)
        for (int a = 0; a < 4; a++)
          for (int sg = 0; sg < 2; sg++)
            for (int p = 0; p < 8; p++) begin
              @(negedge clk);
              big_endian = e[0];
              st_req = 1'b1; st_size = 2'(sz); st_addr = 2'(3 - a);
              st_value = (32'h9E37_79B9 * (p + 1)) ^ 32'h8000_8080;
              ld_req = 1'b1; ld_size = 2'(3 - sz); ld_addr = 2'(a); ld_signed = sg[0];
              rd_word = (32'h7F4A_7C15 * (p + 3)) ^ {p[0] ? 32'h8080_8080 : 32'h0};
              es = exp_store(e[0], st_size, st_addr, st_value);
              step();
              chk(e ? {st_tag(st_size, st_addr), " R9 data"} : {st_tag(st_size, st_addr), " R8 data"},
                  wr_data, es[31:0]);
              chk(e ? {st_tag(st_size, st_addr), " R9 be"} : {st_tag(st_size, st_addr), " R8 be"},
                  {28'h0, wr_be}, {28'h0, es[35:32]});
              chk(e ? {ld_tag(ld_size, ld_addr, ld_signed), " R9 load"}
                    : {ld_tag(ld_size, ld_addr, ld_signed), " R8 load"},
                  ld_data, exp_load(e[0], ld_size, ld_addr, ld_signed, rd_word));
            end

    // R11: idle cycle clears enables, load result holds
    @(negedge clk);
    held = ld_data;
    st_req = 1'b0; ld_req = 1'b0; rd_word = 32'hDEAD_BEEF; ld_size = 2'd2;
    step();
    chk("R11 idle wr_be", {28'h0, wr_be}, 32'h0);
    chk("R11 ld_data hold", ld_data, held);
    step();
    chk("R11 ld_data hold 2", ld_data, held);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule